// File: doc/BRIEF.md
# Bus-Snooping Dual-Lane Checksum Unit

This block watches a 32-bit data bus and, while software has switched it on, folds every transfer it sees into a running Internet-style checksum. Each transfer's lower 16 bits go into one ones-complement lane and its upper 16 bits into a second lane. Software clears the unit, turns it on, and lets a DMA or programmed-I/O transfer run past it. It then collects either the raw two-lane sum or the finished 16-bit checksum.

Each lane adder is split into short segments. A carry register sits between segments, and the carry out of the top segment wraps around to the bottom one. The adder therefore takes a new word every clock, and carries keep moving around the ring on later clocks. Once enough clocks have passed with no new input, every carry has been absorbed. At that point a valid flag rises. The finished checksum is formed by adding the two lanes, adding the carry of that sum back in, and inverting the result.

Top module: `csum_snoop`

## Requirements
- R1: After reset the enable bit reads 0, the raw sum reads 0, `sum_valid` is 0 and `bus_rdata` is 0.
- R2: Bit 0 of the control location (address 0) is the enable: 1 sums, 0 does not. Snooped transfers seen while it is 0 leave the raw sum unchanged. Reading address 0 returns the enable in bit 0.
- R3: While enabled, every cycle with `snoop_vld` high adds `snoop_data[15:0]` into the low lane and `snoop_data[31:16]` into the high lane, each with end-around carry. A lane's value is 0 only if every word summed into it was 0.
- R4: A read of address 1 returns the 32-bit raw sum (high lane in bits 31:16) on `bus_rdata` in the cycle after `bus_rd`. The read leaves the sum unchanged.
- R5: A write of any value to address 1 clears the sum and every pending carry. A snooped transfer in the same cycle is discarded.
- R6: After a clear, a single accumulated transfer seeds the raw sum with exactly that value.
- R7: A read of address 2 returns the checksum in bits 15:0 and `sum_valid` in bit 16, with all other bits 0. The checksum is the bitwise inverse of (high + low, then plus the carry of that sum). Writes to address 2 have no effect.
- R8: `sum_valid` goes to 0 on the clock edge of any accumulation or clear. It goes to 1 on the fifth following edge with no accumulation or clear, and by then no carry is pending.
- R9: Reading address 2 before `sum_valid` is set returns the provisional checksum with bit 16 at 0. The read does not alter when `sum_valid` rises.
- R10: Accumulating a block of words and then the word holding that block's checksum in its low 16 bits gives a checksum of 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| snoop_vld | input | 1 | A transfer is on the snooped bus this cycle |
| snoop_data | input | 32 | Data of the snooped transfer |
| bus_addr | input | 2 | Register address: 0 control, 1 raw sum, 2 checksum |
| bus_wr | input | 1 | Single-cycle register write strobe |
| bus_rd | input | 1 | Single-cycle register read strobe |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, updated the cycle after `bus_rd` |
| sum_valid | output | 1 | The sum has settled and the checksum is final |

## Verification
The hardest case to reach from the ports is a carry that must travel the full ring of a lane before it is absorbed. This decides whether five idle clocks are really enough. The stimulus gets there by first filling the sum with all ones and then adding a word with a 1 in each lane. The carry this produces has to ripple through every segment and wrap back before the value settles. The bench checks the valid flag one clock before the deadline and again at it, and reads the raw sum only after the flag is set. Back-to-back snoops of 0xFFFF and 0x8000 patterns keep several carries in flight at the same time.

// File: rtl/csum_snoop.sv
`timescale 1ns/1ps
module csum_snoop #(
  parameter int DATA_W = 32,
  parameter int LANE_W = 16,
  parameter int SEG_W  = 4,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              snoop_vld,
  input  logic [DATA_W-1:0] snoop_data,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              sum_valid
);
  localparam int NLANE  = DATA_W / LANE_W;
  localparam int NSEG   = LANE_W / SEG_W;
  localparam int NCY    = NLANE * NSEG;
  localparam int SETTLE = NSEG + 1;
  localparam int CNT_W  = $clog2(SETTLE + 1);
  localparam int WIDE_W = LANE_W + $clog2(NLANE) + 1;
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_SUM  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_CHK  = ADDR_W'(2);

  logic              en_q;
  logic [DATA_W-1:0] acc_q, acc_d;
  logic [NCY-1:0]    cy_q, cy_d;
  logic [CNT_W-1:0]  idle_cnt;

  wire acc_go = en_q & snoop_vld;
  wire clr    = bus_wr && (bus_addr == A_SUM);
  wire wdata_unused = ^bus_wdata[DATA_W-1:1];

  for (genvar l = 0; l < NLANE; l++) begin : g_lane
    for (genvar s = 0; s < NSEG; s++) begin : g_seg
      localparam int IDX = l * NSEG + s;
      localparam int PRV = l * NSEG + ((s + NSEG - 1) % NSEG);
      localparam int LO  = l * LANE_W + s * SEG_W;
      logic [SEG_W:0] seg_sum;
      assign seg_sum = {1'b0, acc_q[LO +: SEG_W]}
                     + {1'b0, acc_go ? snoop_data[LO +: SEG_W] : {SEG_W{1'b0}}}
                     + {{SEG_W{1'b0}}, cy_q[PRV]};
      assign acc_d[LO +: SEG_W] = seg_sum[SEG_W-1:0];
      assign cy_d[IDX]          = seg_sum[SEG_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      acc_q <= '0;
      cy_q  <= '0;
    end else begin
      if (bus_wr && bus_addr == A_CTRL) en_q <= bus_wdata[0];
      if (clr) begin
        acc_q <= '0;
        cy_q  <= '0;
      end else begin
        acc_q <= acc_d;
        cy_q  <= cy_d;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idle_cnt  <= '0;
      sum_valid <= 1'b0;
    end else if (clr || acc_go) begin
      idle_cnt  <= '0;
      sum_valid <= 1'b0;
    end else if (idle_cnt != CNT_W'(SETTLE)) begin
      idle_cnt  <= idle_cnt + 1'b1;
      sum_valid <= (idle_cnt == CNT_W'(SETTLE - 1));
    end
  end

  logic [WIDE_W-1:0] wide;
  logic [LANE_W:0]   fold1;
  logic [LANE_W-1:0] fold2, chk;

  always_comb begin
    wide = '0;
    for (int l = 0; l < NLANE; l++)
      wide = wide + WIDE_W'(acc_q[l*LANE_W +: LANE_W]);
  end

  assign fold1 = {1'b0, wide[LANE_W-1:0]} + (LANE_W+1)'(wide[WIDE_W-1:LANE_W]);
  assign fold2 = fold1[LANE_W-1:0] + LANE_W'(fold1[LANE_W]);
  assign chk   = ~fold2;

  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      A_CTRL:  rd_mux[0] = en_q;
      A_SUM:   rd_mux = acc_q;
      A_CHK: begin
        rd_mux[LANE_W-1:0] = chk;
        rd_mux[LANE_W]     = sum_valid;
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end
endmodule

module csum_snoop_chk #(
  parameter int DATA_W = 32,
  parameter int NCY    = 8,
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              snoop_vld,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              sum_valid,
  input logic              en_q,
  input logic [DATA_W-1:0] acc_q,
  input logic [NCY-1:0]    cy_q
);
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(1)) |=> (acc_q == '0 && cy_q == '0)); // R5

  AST_SETTLED_NO_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    sum_valid |-> (cy_q == '0)); // R8

  AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    ((en_q && snoop_vld) || (bus_wr && bus_addr == ADDR_W'(1))) |=> !sum_valid); // R8

  AST_DISABLED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !bus_wr && cy_q == '0) |=> (acc_q == $past(acc_q))); // R2

  AST_READ_KEEPS_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr && !(en_q && snoop_vld) && cy_q == '0) |=> $stable(acc_q)); // R4

  AST_CTRL_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr && bus_addr == ADDR_W'(0)) |=> (bus_rdata == DATA_W'($past(en_q)))); // R2
endmodule

bind csum_snoop csum_snoop_chk #(.DATA_W(DATA_W), .NCY(NCY), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .snoop_vld(snoop_vld), .bus_addr(bus_addr),
  .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .sum_valid(sum_valid),
  .en_q(en_q), .acc_q(acc_q), .cy_q(cy_q)
);

// File: tb/csum_snoop_tb.sv
`timescale 1ns/1ps
module csum_snoop_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        snoop_vld = 1'b0;
  logic [31:0] snoop_data = '0;
  logic [1:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        sum_valid;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #2.5 clk = ~clk;

  csum_snoop u_dut (
    .clk(clk), .rst_n(rst_n), .snoop_vld(snoop_vld), .snoop_data(snoop_data),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .sum_valid(sum_valid)
  );

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb[$];

  logic        m_en = 1'b0;
  logic [15:0] m_lo = '0, m_hi = '0;

  function automatic logic [15:0] oc_add(input logic [15:0] a, input logic [15:0] b);
    logic [16:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[15:0] + {15'd0, s[16]};
  endfunction

  function automatic logic [15:0] m_chk();
    return ~oc_add(m_hi, m_lo);
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  logic rd_seen = 1'b0;
  always @(posedge clk) rd_seen <= bus_rd;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (sb.size() == 0) check(bus_rdata, 32'hx, "scoreboard underflow");
      else begin
        item_t it;
        it = sb.pop_front();
        check(bus_rdata, it.exp, it.tag);
      end
    end
  end

  task automatic tick(); @(negedge clk); endtask

  task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    tick();
    bus_wr = 1'b0;
    if (a == 2'd0) m_en = d[0];
    if (a == 2'd1) begin m_lo = '0; m_hi = '0; end
  endtask

  task automatic bus_read(input logic [1:0] a, input logic [31:0] exp, input string tag);
    item_t it;
    it.exp = exp; it.tag = tag;
    sb.push_back(it);
    bus_addr = a; bus_rd = 1'b1;
    tick();
    bus_rd = 1'b0;
  endtask

  task automatic snoop(input logic [31:0] d);
    snoop_data = d; snoop_vld = 1'b1;
    tick();
    snoop_vld = 1'b0;
    if (m_en) begin
      m_lo = oc_add(m_lo, d[15:0]);
      m_hi = oc_add(m_hi, d[31:16]);
    end
  endtask

  task automatic settle(); repeat (6) tick(); endtask

  function automatic logic [31:0] chk_word(input logic v);
    return {15'd0, v, m_chk()};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    check({31'd0, sum_valid}, 32'd0, "R1 valid after reset");
    check(bus_rdata, 32'd0, "R1 rdata after reset");
    bus_read(2'd0, 32'd0, "R1 enable after reset");
    bus_read(2'd1, 32'd0, "R1 sum after reset");

    snoop(32'h1234_5678);
    settle();
    bus_read(2'd1, 32'd0, "R2 disabled snoop ignored");

    bus_write(2'd0, 32'h0000_0001);
    bus_read(2'd0, 32'd1, "R2 enable readback");

    bus_write(2'd1, 32'hDEAD_BEEF);
    snoop(32'h0000_ABCD);
    settle();
    bus_read(2'd1, 32'h0000_ABCD, "R6 seed value");
    bus_read(2'd1, 32'h0000_ABCD, "R4 second read unchanged");

    bus_write(2'd1, 32'h0);
    snoop(32'h0102_0304);
    repeat (4) tick();
    check({31'd0, sum_valid}, 32'd0, "R8 valid low at 4 idle edges");
    tick();
    check({31'd0, sum_valid}, 32'd1, "R8 valid high at 5 idle edges");

    bus_write(2'd1, 32'h0);
    foreach (sb[i]) ;
    for (int i = 0; i < 24; i++) begin
      logic [31:0] w;
      case (i % 4)
        0: w = 32'hFFFF_FFFF;
        1: w = 32'h8000_8000;
        2: w = 32'h1357_9BDF ^ (i * 32'h0101_3131);
        default: w = {i[15:0] * 16'h2F1, 16'hFFFE - i[15:0]};
      endcase
      snoop(w);
    end
    settle();
    bus_read(2'd1, {m_hi, m_lo}, "R3 burst raw sum");
    bus_read(2'd2, chk_word(1'b1), "R7 burst checksum");

    bus_write(2'd2, 32'h0000_0000);
    bus_read(2'd1, {m_hi, m_lo}, "R7 write to checksum ignored (sum)");
    bus_read(2'd2, chk_word(1'b1), "R7 write to checksum ignored (chk)");

    bus_write(2'd1, 32'h0);
    snoop(32'h4321_00F0);
    bus_read(2'd2, chk_word(1'b0), "R9 provisional read");
    repeat (3) tick();
    check({31'd0, sum_valid}, 32'd0, "R9 valid still low after read");
    tick();
    check({31'd0, sum_valid}, 32'd1, "R9 valid rises on time");

    bus_write(2'd1, 32'h0);
    snoop(32'h0000_0011);
    settle();
    bus_addr = 2'd1; bus_wdata = 32'h5; bus_wr = 1'b1;
    snoop_data = 32'h7777_7777; snoop_vld = 1'b1;
    tick();
    bus_wr = 1'b0; snoop_vld = 1'b0;
    m_lo = '0; m_hi = '0;
    settle();
    bus_read(2'd1, 32'd0, "R5 clear beats same-cycle snoop");

    snoop(32'hFFFF_FFFF);
    settle();
    snoop(32'h0001_0001);
    repeat (4) tick();
    check({31'd0, sum_valid}, 32'd0, "R8 ring carry not yet settled");
    tick();
    check({31'd0, sum_valid}, 32'd1, "R8 ring carry settled");
    bus_read(2'd1, {m_hi, m_lo}, "R3 full-lap carry result");

    bus_write(2'd1, 32'h0);
    snoop(32'h4500_0073);
    snoop(32'h0000_4000);
    snoop(32'h4011_C0A8);
    snoop(32'h0001_C0A8);
    snoop(32'hFFC7_0102);
    settle();
    snoop({16'd0, m_chk()});
    settle();
    bus_read(2'd2, {15'd0, 1'b1, 16'h0000}, "R10 data plus checksum gives zero");

    bus_write(2'd0, 32'h0);
    bus_read(2'd0, 32'd0, "R2 disable readback");
    snoop(32'hABCD_EF01);
    settle();
    bus_read(2'd1, {m_hi, m_lo}, "R2 snoop ignored after disable");

    repeat (3) tick();
    if (sb.size() != 0) check(sb.size(), 0, "scoreboard drained");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule